// File: doc/BRIEF.md
# Shifting Mailbox Queue

This block holds the words travelling in one direction of an inter-processor mailbox. A producer writes words at the tail and a consumer takes them from the head. Each time a word leaves, the remaining words move one place toward slot 0, so the oldest word always sits in slot 0. Any slot that holds no message contains a fixed marker word, which is set by parameter `MARKER`. Reading an empty queue returns that marker. A separate peek output shows the head word without removing it. The block reports its fill level as a count and as a packed status word.

Both sides use valid/ready, and the ready signals act as advice to the other side. On the input side, `push_ready` is high while the queue has room. A word offered with `push_valid` is taken on a rising edge only if `push_ready` was high in that cycle. An offer made while the queue is full is dropped and flagged on `overflow`; it is not held for a later cycle. On the output side, `pop_valid` is high while the queue holds a word, and `pop_data` always shows the head. The consumer takes the head by raising `pop_ready`. Raising `pop_ready` while the queue is empty is flagged on `underflow`.

`clear` empties the queue synchronously. The asynchronous active-low reset `rst_n` brings the block to the same state as `clear`.

Top module: `mbq_shift_fifo`

## Requirements
- R1: After reset, `count` is 0 and every slot holds `MARKER` (default 32'hFFFF_FFFF). `peek_data` and `pop_data` show `MARKER`, `push_ready` is 1, `pop_valid` is 0, and neither pulse is high.
- R2: `status` bit 31 is 1 exactly when `count` equals `DEPTH` (default 8), and bit 30 is 1 exactly when `count` is 0. Bits [CW-1:0] carry `count`, with CW = clog2(DEPTH+1). All other bits are 0. `status` follows `count` in every cycle.
- R3: `push_ready` is 1 exactly when `count` < `DEPTH`. An accepted push stores `push_data` at index `count` and raises `count` by one on the same edge.
- R4: A push offered while the queue is full changes no slot and leaves `count` unchanged. In the following cycle, `overflow` is high for exactly one cycle.
- R5: An accepted pop delivers the head word on `pop_data` in the request cycle. On that edge, every later occupied slot moves down by one, `count` falls by one, and the freed slot becomes `MARKER`. Words therefore leave in the order they arrived, and a queue drained empty shows `MARKER` again.
- R6: A pop request while `count` is 0 returns `MARKER` on `pop_data` and changes no state. In the following cycle, `underflow` is high for exactly one cycle.
- R7: `peek_data` always equals slot 0, which is `MARKER` when the queue is empty. Observing it never changes the queue.
- R8: When push and pop are both requested on a queue that is neither empty nor full, the head leaves, the new word lands at the tail, and `count` stays the same. If the queue is full, only the pop happens and `overflow` pulses. If the queue is empty, only the push happens and `underflow` pulses.
- R9: `clear` takes priority over push and pop. On the next edge, `count` becomes 0 and every slot becomes `MARKER`. A clear cycle raises no overflow or underflow pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous empty request |
| push_valid | input | 1 | Producer offers a word |
| push_data | input | DW | Word offered by producer |
| push_ready | output | 1 | Queue has room |
| pop_ready | input | 1 | Consumer takes the head |
| pop_valid | output | 1 | Queue holds a word |
| pop_data | output | DW | Head word, or marker when empty |
| peek_data | output | DW | Slot 0, never removed |
| count | output | CW | Number of stored words |
| status | output | 32 | Full bit 31, empty bit 30, count in low bits |
| overflow | output | 1 | One-cycle pulse after a rejected push |
| underflow | output | 1 | One-cycle pulse after a pop on empty |

## Verification
The assertions check several things on every cycle:
- the full and empty flags are never both set;
- an empty queue shows the marker at its head;
- `count` steps by exactly the amount that accepted pushes and pops require;
- rejected requests produce their pulse and leave `count` alone;
- after a shifting pop, slot 0 holds what slot 1 held;
- a clear leaves the queue empty and produces no pulse.

What the per-cycle checks cannot show is the order of the words, the presence of the marker in freed slots, and the outcome of mixed push/pop/clear sequences. These are shown only by the bench's scenarios, which compare every output each cycle against a behavioural queue model: filling to full, a rejected push, a pop and push together at full, at empty and part-full, a drain past empty, a clear while push and pop are also requested, and a long pseudo-random run.

// File: rtl/mbq_pkg.sv
package mbq_pkg;
  localparam int unsigned STAT_W    = 32;
  localparam int unsigned FULL_BIT  = 31;
  localparam int unsigned EMPTY_BIT = 30;

  typedef enum logic [1:0] {
    SL_HOLD  = 2'd0,
    SL_SHIFT = 2'd1,
    SL_LOAD  = 2'd2,
    SL_FREE  = 2'd3
  } slot_op_e;
endpackage

// File: rtl/mbq_slot.sv
module mbq_slot
  import mbq_pkg::*;
#(
  parameter int unsigned    DW     = 32,
  parameter logic [DW-1:0]  MARKER = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  slot_op_e      op,
  input  logic [DW-1:0] up_val,
  input  logic [DW-1:0] in_val,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= MARKER;
    end else begin
      case (op)
        SL_SHIFT: q <= up_val;
        SL_LOAD:  q <= in_val;
        SL_FREE:  q <= MARKER;
        default:  q <= q;
      endcase
    end
  end
endmodule

// File: rtl/mbq_status.sv
module mbq_status
  import mbq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0]     count,
  output logic              full,
  output logic              empty,
  output logic [STAT_W-1:0] status
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  assign full  = (count == DEPTH_C);
  assign empty = (count == '0);

  always_comb begin
    status            = '0;
    status[CW-1:0]    = count;
    status[FULL_BIT]  = full;
    status[EMPTY_BIT] = empty;
  end
endmodule

// File: rtl/mbq_ctrl.sv
module mbq_ctrl
  import mbq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          push_req,
  input  logic          pop_req,
  input  logic          full,
  input  logic          empty,
  output logic [CW-1:0] count,
  output logic          do_push,
  output logic          do_pop,
  output logic          overflow,
  output logic          underflow,
  output slot_op_e      ops [DEPTH]
);
  logic [CW-1:0] count_q;
  logic          ovf_q, udf_q;
  int            cnt_i;

  assign do_push = push_req && !full  && !clear;
  assign do_pop  = pop_req  && !empty && !clear;
  assign cnt_i   = int'(count_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      ovf_q <= push_req && full  && !clear;
      udf_q <= pop_req  && empty && !clear;
      if (clear)                  count_q <= '0;
      else if (do_push && !do_pop) count_q <= count_q + 1'b1;
      else if (do_pop && !do_push) count_q <= count_q - 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      ops[i] = SL_HOLD;
      if (clear) begin
        ops[i] = SL_FREE;
      end else if (do_pop) begin
        if (i + 1 == cnt_i)     ops[i] = do_push ? SL_LOAD : SL_FREE;
        else if (i + 1 < cnt_i) ops[i] = SL_SHIFT;
      end else if (do_push && i == cnt_i) begin
        ops[i] = SL_LOAD;
      end
    end
  end

  assign count     = count_q;
  assign overflow  = ovf_q;
  assign underflow = udf_q;

  p_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && !full && !pop_req && !clear) |=> (count_q == CW'($past(count_q) + 1'b1)));

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_req && !clear) |=> (overflow && $stable(count_q)));

  p_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !empty && !push_req && !clear) |=> (count_q == CW'($past(count_q) - 1'b1)));

  p_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && empty && !push_req && !clear) |=> (underflow && $stable(count_q)));

  p_pushpop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_req && !full && !empty && !clear) |=> $stable(count_q));

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count_q == '0 && !overflow && !underflow));
endmodule

// File: rtl/mbq_shift_fifo.sv
module mbq_shift_fifo
  import mbq_pkg::*;
#(
  parameter int unsigned   DEPTH  = 8,
  parameter int unsigned   DW     = 32,
  parameter logic [DW-1:0] MARKER = 32'hFFFF_FFFF,
  parameter int unsigned   CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push_valid,
  input  logic [DW-1:0]     push_data,
  output logic              push_ready,
  input  logic              pop_ready,
  output logic              pop_valid,
  output logic [DW-1:0]     pop_data,
  output logic [DW-1:0]     peek_data,
  output logic [CW-1:0]     count,
  output logic [STAT_W-1:0] status,
  output logic              overflow,
  output logic              underflow
);
  logic          full, empty, do_push, do_pop;
  slot_op_e      ops   [DEPTH];
  logic [DW-1:0] slot  [DEPTH];

  mbq_status #(.DEPTH(DEPTH), .CW(CW)) u_status (
    .count (count),
    .full  (full),
    .empty (empty),
    .status(status)
  );

  mbq_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .push_req (push_valid),
    .pop_req  (pop_ready),
    .full     (full),
    .empty    (empty),
    .count    (count),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .overflow (overflow),
    .underflow(underflow),
    .ops      (ops)
  );

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    logic [DW-1:0] up_val;
    if (g == int'(DEPTH) - 1) begin : g_last
      assign up_val = MARKER;
    end else begin : g_mid
      assign up_val = slot[g+1];
    end
    mbq_slot #(.DW(DW), .MARKER(MARKER)) u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .op    (ops[g]),
      .up_val(up_val),
      .in_val(push_data),
      .q     (slot[g])
    );
  end

  assign push_ready = !full;
  assign pop_valid  = !empty;
  assign peek_data  = slot[0];
  assign pop_data   = slot[0];

  p_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(status[FULL_BIT] && status[EMPTY_BIT]));

  p_empty_marker_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status[EMPTY_BIT] |-> (peek_data == MARKER));

  p_head_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (do_pop && !do_push && count > CW'(1)) |=> (peek_data == $past(slot[1])));
endmodule

// File: tb/mbq_shift_fifo_tb.sv
module mbq_shift_fifo_tb;
  localparam int          DEPTH = 8;
  localparam int          CW    = 4;
  localparam logic [31:0] MARK  = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clear = 1'b0;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic        pop_ready = 1'b0;
  logic        push_ready, pop_valid, overflow, underflow;
  logic [31:0] pop_data, peek_data, status;
  logic [CW-1:0] count;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string ph = "R1";

  logic [31:0] mq[$];
  bit          e_ovf = 1'b0, e_udf = 1'b0;

  always #2 clk = ~clk;

  mbq_shift_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop_ready(pop_ready), .pop_valid(pop_valid), .pop_data(pop_data),
    .peek_data(peek_data), .count(count), .status(status),
    .overflow(overflow), .underflow(underflow)
  );

  always @(posedge clk) begin
    bit full, empty;
    e_ovf = 1'b0;
    e_udf = 1'b0;
    if (!rst_n || clear) begin
      mq.delete();
    end else begin
      full  = (mq.size() == DEPTH);
      empty = (mq.size() == 0);
      e_ovf = push_valid && full;
      e_udf = pop_ready && empty;
      if (pop_ready && !empty) void'(mq.pop_front());
      if (push_valid && !full) mq.push_back(push_data);
    end
  end

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] es, head;
    int sz;
    sz   = mq.size();
    head = (sz > 0) ? mq[0] : MARK;
    es = '0;
    es[CW-1:0] = CW'(sz);
    es[31] = (sz == DEPTH);
    es[30] = (sz == 0);
    chk({ph, "/R2"}, "count",      32'(count),      32'(sz));
    chk({ph, "/R2"}, "status",     status,          es);
    chk({ph, "/R7"}, "peek_data",  peek_data,       head);
    chk({ph, "/R5"}, "pop_data",   pop_data,        head);
    chk({ph, "/R3"}, "push_ready", 32'(push_ready), 32'(sz < DEPTH));
    chk({ph, "/R5"}, "pop_valid",  32'(pop_valid),  32'(sz > 0));
    chk({ph, "/R4"}, "overflow",   32'(overflow),   32'(e_ovf));
    chk({ph, "/R6"}, "underflow",  32'(underflow),  32'(e_udf));
  endtask

  task automatic cyc(bit pv, logic [31:0] pd, bit pr, bit clr);
    push_valid = pv;
    push_data  = pd;
    pop_ready  = pr;
    clear      = clr;
    @(negedge clk);
    compare();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    ph = "R1";
    compare();
    chk("R1", "peek after reset", peek_data, MARK);
    cyc(0, 0, 0, 0);

    ph = "R3";
    for (int i = 0; i < DEPTH; i++) cyc(1, 32'h1000 + i, 0, 0);

    ph = "R4";
    cyc(1, 32'hBAD0, 0, 0);
    cyc(1, 32'hBAD1, 0, 0);
    cyc(0, 0, 0, 0);
    chk("R4", "count after rejected push", 32'(count), 32'(DEPTH));

    ph = "R8";
    cyc(1, 32'h2000, 1, 0);
    for (int i = 0; i < 3; i++) cyc(1, 32'h2001 + i, 1, 0);
    chk("R8", "count steady under push+pop", 32'(count), 32'(DEPTH - 1));

    ph = "R5";
    for (int i = 0; i < DEPTH - 1; i++) cyc(0, 0, 1, 0);
    chk("R5", "drained head is marker", peek_data, MARK);

    ph = "R6";
    cyc(0, 0, 1, 0);
    cyc(0, 0, 1, 0);
    cyc(0, 0, 0, 0);

    ph = "R8";
    cyc(1, 32'h3000, 1, 0);
    cyc(0, 0, 0, 0);
    chk("R8", "push on empty with pop", peek_data, 32'h3000);

    ph = "R9";
    for (int i = 0; i < 3; i++) cyc(1, 32'h4000 + i, 0, 0);
    cyc(1, 32'h4444, 1, 1);
    chk("R9", "count after clear", 32'(count), 0);
    cyc(0, 0, 0, 0);

    ph = "R7";
    cyc(1, 32'h5555_0000, 0, 0);
    cyc(1, 32'h5555_0001, 0, 0);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    chk("R7", "peek stable", peek_data, 32'h5555_0000);

    ph = "MIX";
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[3], {16'h6000, lfsr}, lfsr[1] & lfsr[5],
          lfsr[7:2] == 6'h3F);
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule